// File: doc/BRIEF.md
# Sector Reed-Solomon Parity Engine

This block sits in a flash controller's data path and computes Reed-Solomon check symbols over one sector of data bytes as they stream past. Symbols are 10 bits wide over GF(2^10) with field polynomial x^10 + x^3 + 1. The generator has roots alpha^0 through alpha^5, so it yields six check symbols (60 bits), carried in eight spare-area bytes.

Each byte is inverted and zero-extended to a 10-bit symbol before it enters the division register. A blank sector of 0xFF bytes therefore produces an all-ones code. In generate mode the engine divides the sector and presents inverted parity bytes for storing. In check mode it divides the sector again and then takes in the eight stored bytes. From these it forms a remainder. An error flag is raised if any remainder bit is set. The remainder can be read back in bit-reversed byte order so that software can locate and correct errors.

Software drives a control write: bit 7 clears, bit 6 selects generate, and bit 5 lets valid bytes through. Writing 0x00 freezes the engine so results can be read out. Two byte-wide banks, parity and remainder, are read by index.

Top module: `rs_page_parity`

## Requirements
- R1: After reset the parity bank reads 0xFF in all eight bytes, the remainder bank reads 0x00 in all eight bytes and the error flag is low.
- R2: In generate mode (control 0xE0), after SECTOR_BYTES accepted bytes, the following form a codeword that vanishes at alpha^0..alpha^5:
  - the sector symbols (inverted bytes, first byte highest degree);
  - then the six symbols from the inverted, packed parity bank.
- R3: A sector of all 0xFF bytes gives 0xFF in every parity bank byte.
- R4: Packing is little-endian over 64 bits: the highest-degree check symbol sits at bits 9:0, the next at 19:10, and so on to the degree-0 symbol at 59:50. Parity bank byte 7 always reads 1111 in bits 7:4.
- R5: A control write with bit 7 set zeroes the division register and byte count, so the parity bank reads all 0xFF on the next cycle.
- R6: Bytes presented with valid low, or while bit 5 of the last control write is clear, change nothing. Feeding resumes where it stopped after bit 5 is set again without bit 7.
- R7: In generate mode, bytes beyond the SECTOR_BYTES-th are ignored.
- R8: In check mode (control 0xA0), if the sector and the eight stored bytes match what generate mode produced, the flag stays low and the remainder bank reads all zero.
- R9: In check mode, if the stored bytes differ from the generated ones in bits 59:0, the flag is set. Remainder byte k then equals the XOR of the generated and stored byte k, masked to bits 59:0, with its bit order reversed.
- R10: A single bit flipped in the sector during check mode sets the flag.
- R11: The flag is low in every cycle before the eighth stored byte has been absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control value: bit 7 clear, bit 6 generate, bit 5 feed enable |
| din_valid | input | 1 | Data byte valid |
| din | input | 8 | Data or stored-code byte |
| chk_err | output | 1 | Error flag (nonzero remainder after the stored code) |
| rd_bank | input | 1 | Bank select: 0 parity, 1 remainder |
| rd_sel | input | 3 | Byte index within the bank |
| rd_data | output | 8 | Selected byte |

## Verification
The bench uses the default 512-byte sector. This exercises the full byte count, the switch from data to stored code at byte 512, and the cut-off of extra bytes in generate mode, all on a real sector length. Each sector takes about 530 cycles, so about twenty random and directed sectors fit comfortably. Each generated code is checked by evaluating the codeword at all six roots in the bench. Single-bit faults are placed in both the sector and the stored code.

// File: rtl/rs_page_parity.sv
module rs_page_parity #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       din_valid,
  input  logic [7:0] din,
  output logic       chk_err,
  input  logic       rd_bank,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data
);
  localparam int SYM_W = 10;
  localparam int NPAR = 6;
  localparam int CODE_BYTES = (NPAR*SYM_W + 7) / 8;
  localparam int CODE_W = CODE_BYTES * 8;
  localparam int CNT_W = $clog2(SECTOR_BYTES + CODE_BYTES + 1);
  localparam logic [CNT_W-1:0] SEC_END = CNT_W'(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] ALL_END = CNT_W'(SECTOR_BYTES + CODE_BYTES);
  localparam logic [CODE_W-1:0] USED = {{(CODE_W-NPAR*SYM_W){1'b0}}, {(NPAR*SYM_W){1'b1}}};

  function automatic logic [SYM_W-1:0] gmul(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ 10'h009) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [SYM_W-1:0] gen_coef(input int k);
    logic [SYM_W-1:0] g [0:NPAR];
    logic [SYM_W-1:0] a;
    for (int i = 0; i <= NPAR; i++) g[i] = '0;
    g[0] = 10'd1;
    a = 10'd1;
    for (int j = 0; j < NPAR; j++) begin
      for (int i = NPAR; i >= 1; i--) g[i] = g[i-1] ^ gmul(g[i], a);
      g[0] = gmul(g[0], a);
      a = gmul(a, 10'd2);
    end
    return g[k];
  endfunction

  logic [NPAR-1:0][SYM_W-1:0] r, r_nxt;
  logic [CNT_W-1:0] cnt;
  logic [CODE_W-1:0] stored, packed_r, rem, syn;
  logic gen, en, done;
  logic [SYM_W-1:0] fb;

  assign fb = {{(SYM_W-8){1'b0}}, ~din} ^ r[NPAR-1];

  for (genvar i = 0; i < NPAR; i++) begin : g_stage
    localparam logic [SYM_W-1:0] GC = gen_coef(i);
    if (i == 0) begin : g_first
      assign r_nxt[i] = gmul(fb, GC);
    end else begin : g_rest
      assign r_nxt[i] = r[i-1] ^ gmul(fb, GC);
    end
  end

  always_comb begin
    packed_r = '0;
    for (int k = 0; k < NPAR; k++) packed_r[k*SYM_W +: SYM_W] = r[NPAR-1-k];
  end

  assign done = !gen && (cnt == ALL_END);
  assign rem = done ? ((packed_r ^ ~stored) & USED) : '0;
  assign chk_err = |rem;

  always_comb begin
    for (int k = 0; k < CODE_BYTES; k++)
      for (int b = 0; b < 8; b++) syn[k*8+b] = rem[k*8+7-b];
  end

  assign rd_data = rd_bank ? syn[{rd_sel, 3'b000} +: 8] : ~packed_r[{rd_sel, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r <= '0;
      cnt <= '0;
      stored <= '0;
      gen <= 1'b0;
      en <= 1'b0;
    end else if (ctl_we) begin
      gen <= ctl_wdata[6];
      en <= ctl_wdata[5];
      if (ctl_wdata[7]) begin
        r <= '0;
        cnt <= '0;
        stored <= '0;
      end
    end else if (din_valid && en) begin
      if (cnt < SEC_END) begin
        r <= r_nxt;
        cnt <= cnt + CNT_W'(1);
      end else if (!gen && cnt < ALL_END) begin
        stored <= {din, stored[CODE_W-1:8]};
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

module rs_page_parity_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W = 10,
  parameter int RW = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic             din_valid,
  input logic             en,
  input logic             gen,
  input logic [CNT_W-1:0] cnt,
  input logic [RW-1:0]    r,
  input logic             chk_err,
  input logic             rd_bank,
  input logic [2:0]       rd_sel,
  input logic [7:0]       rd_data
);
  localparam logic [CNT_W-1:0] SEC_END = CNT_W'(SECTOR_BYTES);
  localparam logic [CNT_W-1:0] ALL_END = CNT_W'(SECTOR_BYTES + 8);

  AST_FLAG_AFTER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> (!gen && cnt == ALL_END)); // R11
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[7]) |=> (cnt == '0 && r == '0)); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !(din_valid && en)) |=> ($stable(r) && $stable(cnt))); // R6
  AST_GEN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && gen && cnt == SEC_END) |=> ($stable(r) && $stable(cnt))); // R7
  AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_bank && rd_sel == 3'd7) |-> (rd_data[7:4] == 4'hF)); // R4
endmodule

bind rs_page_parity rs_page_parity_chk #(
  .SECTOR_BYTES(SECTOR_BYTES), .CNT_W(CNT_W), .RW(NPAR*SYM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .din_valid(din_valid), .en(en), .gen(gen), .cnt(cnt), .r(r),
  .chk_err(chk_err), .rd_bank(rd_bank), .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/rs_page_parity_bench.sv
`timescale 1ns/1ps
module rs_page_parity_bench;
  localparam int SEC = 512;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, din_valid = 1'b0, rd_bank = 1'b0, chk_err;
  logic [7:0] ctl_wdata = '0, din = '0, rd_data;
  logic [2:0] rd_sel = '0;
  int errors = 0, checks = 0;
  logic [7:0] page [0:SEC-1];

  always #4 clk = ~clk;

  rs_page_parity #(.SECTOR_BYTES(SEC)) u_rs_page_parity (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .din_valid(din_valid), .din(din), .chk_err(chk_err),
    .rd_bank(rd_bank), .rd_sel(rd_sel), .rd_data(rd_data));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] gm(input logic [9:0] a, input logic [9:0] b);
    logic [19:0] p = '0;
    for (int i = 0; i < 10; i++) if (b[i]) p ^= 20'(a) << i;
    for (int i = 19; i >= 10; i--) if (p[i]) p ^= 20'h409 << (i - 10);
    return p[9:0];
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int b = 0; b < 8; b++) rev8[b] = v[7-b];
  endfunction

  function automatic bit codeword_ok(input logic [63:0] pbank);
    logic [63:0] pk = ~pbank;
    logic [9:0] a = 10'd1, acc;
    bit ok = 1;
    for (int j = 0; j < 6; j++) begin
      acc = '0;
      for (int i = 0; i < SEC; i++) acc = gm(acc, a) ^ {2'b00, ~page[i]};
      for (int k = 0; k < 6; k++) acc = gm(acc, a) ^ pk[k*10 +: 10];
      if (acc != 0) ok = 0;
      a = gm(a, 10'd2);
    end
    return ok;
  endfunction

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); din_valid = 0; ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk); din_valid = 1; din = b;
  endtask

  task automatic idle();
    @(negedge clk); din_valid = 0; din = $urandom_range(0, 255);
  endtask

  task automatic read_all(input logic bank, output logic [63:0] v);
    for (int k = 0; k < 8; k++) begin
      rd_bank = bank; rd_sel = 3'(k); #1;
      v[k*8 +: 8] = rd_data;
    end
  endtask

  task automatic write_page(output logic [63:0] p);
    ctl(8'hE0);
    for (int i = 0; i < SEC; i++) feed(page[i]);
    idle();
    read_all(1'b0, p);
  endtask

  task automatic read_page(input logic [63:0] code, output logic flag, output logic [63:0] s);
    ctl(8'hA0);
    for (int i = 0; i < SEC; i++) feed(page[i]);
    for (int k = 0; k < 7; k++) feed(code[k*8 +: 8]);
    idle();
    check(chk_err == 1'b0, "R11 flag before last code byte", 64'(chk_err), 64'h0);
    feed(code[63:56]);
    ctl(8'h00);
    flag = chk_err;
    read_all(1'b1, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] p, p2, s, bad, exp;
    logic flag;
    void'($urandom(32'h5eed_0417));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_all(1'b0, p);
    check(p == '1, "R1 parity bank after reset", p, '1);
    read_all(1'b1, s);
    check(s == '0, "R1 remainder bank after reset", s, '0);
    check(chk_err == 0, "R1 flag after reset", 64'(chk_err), 0);

    for (int i = 0; i < SEC; i++) page[i] = 8'hFF;
    write_page(p);
    check(p == '1, "R3 erased sector code", p, '1);

    for (int i = 0; i < SEC; i++) page[i] = 8'h00;
    page[SEC-1] = 8'h5A;
    write_page(p);
    check(codeword_ok(p), "R2 sparse sector codeword", p, 0);
    check(p[63:60] == 4'hF, "R4 pad nibble", 64'(p[63:60]), 64'hF);

    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < SEC; i++) page[i] = 8'($urandom_range(0, 255));
      write_page(p);
      check(codeword_ok(p), "R2 random sector codeword", p, 0);
      check(p[63:60] == 4'hF, "R4 pad nibble", 64'(p[63:60]), 64'hF);
    end

    for (int i = 0; i < SEC; i++) page[i] = 8'($urandom_range(0, 255));
    ctl(8'hE0);
    for (int i = 0; i < 200; i++) begin
      feed(page[i]);
      if (i % 7 == 3) idle();
    end
    ctl(8'h40);
    for (int i = 0; i < 20; i++) feed(8'($urandom_range(0, 255)));
    ctl(8'h60);
    for (int i = 200; i < SEC; i++) feed(page[i]);
    idle();
    read_all(1'b0, p);
    check(codeword_ok(p), "R6 gated bytes ignored", p, 0);

    for (int i = 0; i < 5; i++) feed(8'($urandom_range(0, 255)));
    idle();
    read_all(1'b0, p2);
    check(p2 == p, "R7 extra bytes ignored", p2, p);

    ctl(8'hE0);
    read_all(1'b0, p2);
    check(p2 == '1, "R5 clear zeroes register", p2, '1);

    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < SEC; i++) page[i] = 8'($urandom_range(0, 255));
      write_page(p);
      read_page(p, flag, s);
      check(flag == 0, "R8 clean read flag", 64'(flag), 0);
      check(s == '0, "R8 clean remainder", s, '0);

      bad = p ^ (64'd1 << $urandom_range(0, 59));
      if (t == 0) bad = p ^ 64'h0000_0000_0000_0001;
      if (t == 1) bad = p ^ 64'h0800_0000_0000_0000;
      read_page(bad, flag, s);
      for (int k = 0; k < 8; k++) exp[k*8 +: 8] = rev8(((p ^ bad) & 64'h0FFF_FFFF_FFFF_FFFF) >> (k*8));
      check(flag == 1, "R9 code fault flag", 64'(flag), 1);
      check(s == exp, "R9 remainder bytes", s, exp);

      begin
        int idx = $urandom_range(0, SEC-1);
        if (t == 2) idx = 0;
        page[idx] ^= 8'(1 << $urandom_range(0, 7));
        read_page(p, flag, s);
        check(flag == 1, "R10 data fault flag", 64'(flag), 1);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule